// File: doc/BRIEF.md
# Segmented SIMD Leading-One Detector

This combinational block finds the leading one of a 32-bit word that can be split into narrower lanes. The first step of a logarithm-based multiply or divide needs two things from each operand: the position `k` of the highest set bit and the bits below it, which form a fraction. Packed operands of several widths can share one datapath, so this detector must give those values for every lane at once.

The word is cut into eight 4-bit segments. Each segment has its own small cell that reports whether the segment is empty and where its top set bit lies. A lane then takes the most significant segment that is not empty. A one-hot select puts the segments into one of four layouts. The select is decoded into a named configuration: `CFG_Q8`, `CFG_H16_D8`, `CFG_D16` or `CFG_S32`. Every select value leads to exactly one configuration, and all results appear in the same cycle as the inputs.

Results are reported in four output slots. Slot `s` belongs to the lane whose lowest byte is byte `s` of the word. A slot that does not start a lane in the current layout reports nothing.

Top module: `seg_lod_simd`

## Requirements
- R1: With `prec_sel` = 4'b0001, each byte `s` is its own lane and slot `s` reports `k` as the index (0..7) of the highest set bit of that byte.
- R2: With `prec_sel` = 4'b0100, the word forms two 16-bit lanes. Bits 15:0 report in slot 0 and bits 31:16 report in slot 2, each with `k` in 0..15.
- R3: With `prec_sel` = 4'b1000, the whole word is one lane reported in slot 0, with `k` in 0..31.
- R4: With `prec_sel` = 4'b0010, bytes 0 and 1 are 8-bit lanes in slots 0 and 1, and bits 31:16 form a 16-bit lane in slot 2.
- R5: A lane's 31-bit fraction holds the bits below its leading one. The bit just under the leading one sits at fraction bit 30, the next bit at bit 29, and so on. All remaining low bits are zero.
- R6: A lane with no set bit raises its zero flag and reports `k` = 0 and fraction = 0.
- R7: A lane's result depends only on its own bits. Changing bits of any other lane leaves it unchanged.
- R8: Any `prec_sel` value that is not one of the four listed above behaves exactly like 4'b0001.
- R9: A slot that does not start a lane reports zero flag 0, `k` 0 and fraction 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 32 | Packed operand word |
| prec_sel | input | 4 | One-hot lane layout select |
| lane_k | output | 20 | Per-slot leading-one position, 5 bits per slot, slot 0 in the low bits |
| lane_frac | output | 124 | Per-slot left-aligned fraction, 31 bits per slot, slot 0 in the low bits |
| lane_zero | output | 4 | Per-slot all-zero flag |

## Verification
Two functions can meet in the same cycle in two ways. A lane can report all-zero while the lane just below it resolves a leading one right at their shared boundary. A lane can also find its winner in its lowest segment while the segment above it is empty. The bench provokes both with walking-one and filled-below patterns in every layout, and with words whose upper lanes stay fixed while the lower lanes change. After every vector, each slot's `k`, fraction and zero flag are compared with a behavioural model that scans bits one by one.

// File: rtl/lod_pkg.sv
package lod_pkg;
    localparam int WORD_W = 32;
    localparam int SEG_W  = 4;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 2 * BYTE_W;
    localparam int SEL_W  = 4;
    localparam int NSEG   = WORD_W / SEG_W;
    localparam int NSLOT  = WORD_W / BYTE_W;
    localparam int NHALF  = WORD_W / HALF_W;
    localparam int K_W    = $clog2(WORD_W);
    localparam int FRAC_W = WORD_W - 1;

    typedef enum logic [1:0] {
        CFG_Q8,
        CFG_H16_D8,
        CFG_D16,
        CFG_S32
    } lane_cfg_e;
endpackage

// File: rtl/lod_nib_cell.sv
module lod_nib_cell #(
    parameter int SEG_W = 4,
    localparam int POS_W = $clog2(SEG_W)
) (
    input  logic [SEG_W-1:0] nib,
    output logic             empty,
    output logic [POS_W-1:0] pos
);
    always_comb begin
        empty = (nib == '0);
        pos   = '0;
        for (int i = 0; i < SEG_W; i++) begin
            if (nib[i]) pos = POS_W'(i);
        end
    end
endmodule

// File: rtl/lod_lane_pick.sv
module lod_lane_pick #(
    parameter int LANE_W = 8,
    parameter int SEG_W  = 4,
    parameter int WORD_W = 32,
    localparam int NS    = LANE_W / SEG_W,
    localparam int PW    = $clog2(SEG_W),
    localparam int KW    = $clog2(WORD_W)
) (
    input  logic [LANE_W-1:0] data,
    output logic [KW-1:0]     k,
    output logic [WORD_W-2:0] frac,
    output logic              zero
);
    logic [NS-1:0] seg_empty;
    logic [PW-1:0] seg_pos [NS];

    for (genvar s = 0; s < NS; s++) begin : g_seg
        lod_nib_cell #(.SEG_W(SEG_W)) u_cell (
            .nib   (data[s*SEG_W +: SEG_W]),
            .empty (seg_empty[s]),
            .pos   (seg_pos[s])
        );
    end

    // Highest non-empty segment wins; lower segments are overwritten.
    always_comb begin
        zero = 1'b1;
        k    = '0;
        for (int s = 0; s < NS; s++) begin
            if (!seg_empty[s]) begin
                zero = 1'b0;
                k    = KW'(s * SEG_W) + KW'(seg_pos[s]);
            end
        end
    end

    logic [WORD_W-1:0] ext;
    logic [WORD_W-1:0] aligned;
    logic [KW-1:0]     amt;

    always_comb begin
        ext     = WORD_W'(data) << (WORD_W - LANE_W);
        amt     = KW'(LANE_W - 1) - k;
        aligned = ext << amt;
        frac    = zero ? '0 : aligned[WORD_W-2:0];
    end

    always_comb begin
        if (!$isunknown(data)) begin
            AST_LEAD_ONE: assert (zero || ((data >> k) == LANE_W'(1))) else $error("leading one misplaced"); // R1
            AST_ZERO_LANE: assert (!zero || (data == '0 && k == '0 && frac == '0)) else $error("zero lane output"); // R6
            AST_FRAC_TOP: assert (zero || k == '0 || frac[WORD_W-2] == data[k - KW'(1)]) else $error("fraction top bit"); // R5
        end
    end
endmodule

// File: rtl/seg_lod_simd.sv
module seg_lod_simd
    import lod_pkg::*;
(
    input  logic [WORD_W-1:0]        din,
    input  logic [SEL_W-1:0]         prec_sel,
    output logic [NSLOT*K_W-1:0]     lane_k,
    output logic [NSLOT*FRAC_W-1:0]  lane_frac,
    output logic [NSLOT-1:0]         lane_zero
);
    lane_cfg_e cfg;

    always_comb begin
        unique case (prec_sel)
            4'b0001: cfg = CFG_Q8;
            4'b0010: cfg = CFG_H16_D8;
            4'b0100: cfg = CFG_D16;
            4'b1000: cfg = CFG_S32;
            default: cfg = CFG_Q8;
        endcase
    end

    logic [K_W-1:0]    k8  [NSLOT];
    logic [FRAC_W-1:0] f8  [NSLOT];
    logic              z8  [NSLOT];
    logic [K_W-1:0]    k16 [NHALF];
    logic [FRAC_W-1:0] f16 [NHALF];
    logic              z16 [NHALF];
    logic [K_W-1:0]    k32;
    logic [FRAC_W-1:0] f32;
    logic              z32;

    for (genvar b = 0; b < NSLOT; b++) begin : g_b8
        lod_lane_pick #(.LANE_W(BYTE_W), .SEG_W(SEG_W), .WORD_W(WORD_W)) u_pick (
            .data (din[b*BYTE_W +: BYTE_W]),
            .k    (k8[b]),
            .frac (f8[b]),
            .zero (z8[b])
        );
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_h16
        lod_lane_pick #(.LANE_W(HALF_W), .SEG_W(SEG_W), .WORD_W(WORD_W)) u_pick (
            .data (din[h*HALF_W +: HALF_W]),
            .k    (k16[h]),
            .frac (f16[h]),
            .zero (z16[h])
        );
    end

    lod_lane_pick #(.LANE_W(WORD_W), .SEG_W(SEG_W), .WORD_W(WORD_W)) u_w32 (
        .data (din),
        .k    (k32),
        .frac (f32),
        .zero (z32)
    );

    logic [K_W-1:0]    sk [NSLOT];
    logic [FRAC_W-1:0] sf [NSLOT];
    logic              sz [NSLOT];

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            sk[s] = '0;
            sf[s] = '0;
            sz[s] = 1'b0;
        end
        unique case (cfg)
            CFG_Q8: begin
                for (int s = 0; s < NSLOT; s++) begin
                    sk[s] = k8[s];
                    sf[s] = f8[s];
                    sz[s] = z8[s];
                end
            end
            CFG_H16_D8: begin
                for (int s = 0; s < 2; s++) begin
                    sk[s] = k8[s];
                    sf[s] = f8[s];
                    sz[s] = z8[s];
                end
                sk[2] = k16[1];
                sf[2] = f16[1];
                sz[2] = z16[1];
            end
            CFG_D16: begin
                for (int h = 0; h < NHALF; h++) begin
                    sk[2*h] = k16[h];
                    sf[2*h] = f16[h];
                    sz[2*h] = z16[h];
                end
            end
            CFG_S32: begin
                sk[0] = k32;
                sf[0] = f32;
                sz[0] = z32;
            end
            default: begin
            end
        endcase
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_pack
        assign lane_k[s*K_W +: K_W]          = sk[s];
        assign lane_frac[s*FRAC_W +: FRAC_W] = sf[s];
        assign lane_zero[s]                  = sz[s];
    end

    always_comb begin
        if (!$isunknown({din, prec_sel})) begin
            AST_IDLE_SLOTS: assert (prec_sel != 4'b1000 || (lane_zero[NSLOT-1:1] == '0 && lane_k[NSLOT*K_W-1:K_W] == '0)) else $error("idle slot active"); // R9
            AST_WIDE_ZERO: assert (prec_sel != 4'b1000 || lane_zero[0] == (din == '0)) else $error("wide lane zero flag"); // R6
            AST_HALF_ZERO: assert (prec_sel != 4'b0100 || lane_zero[2] == (din[31:16] == '0)) else $error("upper half zero flag"); // R2
            AST_ILLEGAL_SEL: assert ($onehot(prec_sel) || lane_zero == {din[31:24] == '0, din[23:16] == '0, din[15:8] == '0, din[7:0] == '0}) else $error("illegal select layout"); // R8
        end
    end
endmodule

// File: tb/sim_seg_lod_simd.sv
module sim_seg_lod_simd;
    import lod_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [WORD_W-1:0]       din;
    logic [SEL_W-1:0]        prec_sel;
    logic [NSLOT*K_W-1:0]    lane_k;
    logic [NSLOT*FRAC_W-1:0] lane_frac;
    logic [NSLOT-1:0]        lane_zero;

    seg_lod_simd u0 (
        .din       (din),
        .prec_sel  (prec_sel),
        .lane_k    (lane_k),
        .lane_frac (lane_frac),
        .lane_zero (lane_zero)
    );

    int checks   = 0;
    int failures = 0;
    bit done     = 0;
    logic [31:0] lf = 32'hACE1_1234;

    function automatic int width_of(int slot, logic [3:0] sel);
        case (sel)
            4'b1000: return (slot == 0) ? 32 : 0;
            4'b0100: return (slot == 0 || slot == 2) ? 16 : 0;
            4'b0010: return (slot < 2) ? 8 : ((slot == 2) ? 16 : 0);
            default: return 8;
        endcase
    endfunction

    task automatic run_vec(input logic [31:0] d, input logic [3:0] sel, input string tag);
        @(posedge clk);
        #1;
        din      = d;
        prec_sel = sel;
        @(negedge clk);
        for (int s = 0; s < NSLOT; s++) begin
            int          w;
            longint      data;
            int          ek;
            logic [30:0] ef;
            logic        ez;
            string       t;
            w  = width_of(s, sel);
            ek = 0;
            ef = '0;
            ez = 1'b0;
            t  = tag;
            if (w == 0) begin
                t = "R9";
            end else begin
                data = (longint'(d) >> (8 * s)) & ((64'd1 << w) - 1);
                if (data == 0) begin
                    ez = 1'b1;
                end else begin
                    for (int b = 0; b < w; b++) if (data[b]) ek = b;
                    for (int b = ek - 1; b >= 0; b--) ef[30 - (ek - 1 - b)] = data[b];
                end
            end
            checks++;
            if (lane_k[s*K_W +: K_W] !== K_W'(ek) || lane_frac[s*FRAC_W +: FRAC_W] !== ef
                || lane_zero[s] !== ez) begin
                failures++;
                $display("FAIL %s slot=%0d din=%h sel=%b actual k=%0d frac=%h zero=%b expected k=%0d frac=%h zero=%b",
                         t, s, d, sel, lane_k[s*K_W +: K_W], lane_frac[s*FRAC_W +: FRAC_W],
                         lane_zero[s], ek, ef, ez);
            end
        end
    endtask

    task automatic step_lf();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        din      = '0;
        prec_sel = 4'b0001;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset-state style: empty word in every legal layout (R6)
        run_vec(32'h0, 4'b0001, "R6");
        run_vec(32'h0, 4'b0010, "R6");
        run_vec(32'h0, 4'b0100, "R6");
        run_vec(32'h0, 4'b1000, "R6");
        run_vec(32'h00FF_0000, 4'b0001, "R6");

        // R1: four 8-bit lanes, walking one and filled-below
        for (int i = 0; i < 32; i++) run_vec(32'h1 << i, 4'b0001, "R1");
        for (int i = 0; i < 32; i++) run_vec(32'hFFFF_FFFF >> (31 - i), 4'b0001, "R1");

        // R2: two 16-bit lanes
        for (int i = 0; i < 32; i++) run_vec(32'h1 << i, 4'b0100, "R2");
        for (int i = 0; i < 32; i++) run_vec(32'hFFFF_FFFF >> (31 - i), 4'b0100, "R2");

        // R3: one 32-bit lane
        for (int i = 0; i < 32; i++) run_vec(32'h1 << i, 4'b1000, "R3");
        for (int i = 0; i < 32; i++) run_vec(32'hFFFF_FFFF >> (31 - i), 4'b1000, "R3");

        // R4: mixed layout
        for (int i = 0; i < 32; i++) run_vec(32'h1 << i, 4'b0010, "R4");
        for (int i = 0; i < 40; i++) begin
            step_lf();
            run_vec(lf, 4'b0010, "R4");
        end

        // R5: fraction alignment patterns
        run_vec(32'h8000_0001, 4'b1000, "R5");
        run_vec(32'hA5A5_A5A5, 4'b1000, "R5");
        run_vec(32'hA5A5_A5A5, 4'b0100, "R5");
        run_vec(32'hA5A5_A5A5, 4'b0010, "R5");
        run_vec(32'hA5A5_A5A5, 4'b0001, "R5");
        run_vec(32'h0001_0003, 4'b0100, "R5");
        for (int i = 0; i < 40; i++) begin
            step_lf();
            run_vec(lf, 4'b1000, "R5");
        end

        // R7: upper lanes fixed, lower lanes churn
        for (int i = 0; i < 24; i++) begin
            step_lf();
            run_vec({16'h0010, lf[15:0]}, 4'b0100, "R7");
            run_vec({8'h01, 8'h00, lf[15:0]}, 4'b0001, "R7");
            run_vec({16'h0001, lf[15:0]}, 4'b0010, "R7");
        end

        // R8: every non-one-hot select
        for (int s = 0; s < 16; s++) begin
            if (s != 1 && s != 2 && s != 4 && s != 8) begin
                step_lf();
                run_vec(lf, 4'(s), "R8");
                run_vec(32'h0080_0100, 4'(s), "R8");
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule